// File: doc/BRIEF.md
# Accumulator ALU with Selectable First Operand

This block is the arithmetic and logic engine of a small 8-bit datapath. On each strobed clock edge it takes a first operand from one of three general registers and, where the operation needs one, a second operand that is always the B register. It then places the result in its own accumulator register. A zero flag and a carry flag are captured alongside the accumulator so that a later writeback step and the branch logic can use them.

A compare operation runs the subtraction only to set the flags. It leaves the accumulator as it was and latches a one-hot verdict (equal, less than, greater than), which stays valid until the next compare. Instruction decode and the writeback path into the register file sit outside this block. They drive the operation code and the operand select, and they read back the accumulator.

Top module: `alu_acc8`

## Requirements
- R1: While `rst_n` is low, `acc`, `zero_flag`, `carry_flag`, `cmp_eq`, `cmp_lt` and `cmp_gt` are all 0.
- R2: On a clock edge with `strobe` low, none of the registered outputs changes, whatever the other inputs do.
- R3: `sel` picks the first operand N: 0 takes `reg_a`, 1 takes `reg_c`, 2 takes `reg_d`, 3 takes `reg_a`. The second operand is always `reg_b`.
- R4: The add codes are 0 (N+B), 1 (N+B+1) and 8 (N+1). They load the low 8 bits of the sum into `acc`, and the ninth bit of the sum goes into `carry_flag`.
- R5: The subtract codes are 2 (N-B), 3 (N-B-1) and 9 (N-1). They load the low 8 bits of the difference into `acc`, and `carry_flag` is set exactly when the true difference is negative (a borrow).
- R6: The logic codes are 4 (N AND B), 5 (N OR B), 6 (N XOR B) and 7 (NOT N). They load the bitwise result into `acc` and clear `carry_flag`.
- R7: Code 10 shifts N left by one and code 11 shifts N right by one. The vacated bit is filled with 0, and the bit shifted out goes into `carry_flag`.
- R8: Code 12 rotates N left by one and code 13 rotates N right by one. The bit leaving one end enters the other end, and `carry_flag` keeps its previous value.
- R9: For codes 0 to 13, `zero_flag` is set exactly when the 8-bit result loaded into `acc` is 0.
- R10: Code 14 (compare) leaves `acc` unchanged and sets `zero_flag` and `carry_flag` as code 2 would. It also loads exactly one of `cmp_eq`, `cmp_lt`, `cmp_gt` by unsigned comparison of N with B, and those three hold until the next compare.
- R11: Code 15 with `strobe` high changes no registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Execute the operation on this edge |
| op | input | 4 | Operation code |
| sel | input | 2 | First-operand select |
| reg_a | input | 8 | Register A value |
| reg_b | input | 8 | Register B value, second operand |
| reg_c | input | 8 | Register C value |
| reg_d | input | 8 | Register D value |
| acc | output | 8 | Accumulator |
| zero_flag | output | 1 | Result was zero |
| carry_flag | output | 1 | Carry out, borrow, or shifted-out bit |
| cmp_eq | output | 1 | Last compare: N equal to B |
| cmp_lt | output | 1 | Last compare: N below B |
| cmp_gt | output | 1 | Last compare: N above B |

## Verification
A compare updates the flags and the compare verdict in the same cycle that the accumulator must hold its earlier value. The bench provokes this by following an operation that leaves a nonzero accumulator directly with a compare whose operands give a zero or borrow result. It then checks that the flags follow the subtraction while `acc` still shows the value from the previous operation. The same overlap arises between a rotate, which writes the accumulator, and the carry it must leave alone. The bench covers that by loading carry with a shift and then rotating.

// File: rtl/alu_acc8.sv
module alu_acc8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [3:0]   op,
  input  logic [1:0]   sel,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  input  logic [W-1:0] reg_c,
  input  logic [W-1:0] reg_d,
  output logic [W-1:0] acc,
  output logic         zero_flag,
  output logic         carry_flag,
  output logic         cmp_eq,
  output logic         cmp_lt,
  output logic         cmp_gt
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_ADDP = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_SUBM = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_NOT  = 4'd7;
  localparam logic [3:0] OP_INC  = 4'd8;
  localparam logic [3:0] OP_DEC  = 4'd9;
  localparam logic [3:0] OP_SHL  = 4'd10;
  localparam logic [3:0] OP_SHR  = 4'd11;
  localparam logic [3:0] OP_ROL  = 4'd12;
  localparam logic [3:0] OP_ROR  = 4'd13;
  localparam logic [3:0] OP_CMP  = 4'd14;
  localparam logic [W:0] ONE     = (W+1)'(1);

  logic [W-1:0] n;
  logic [W:0]   nx, bx, wide;
  logic [W-1:0] res;
  logic         cy, load_acc, load_flags;

  assign n  = (sel == 2'd1) ? reg_c : (sel == 2'd2) ? reg_d : reg_a;
  assign nx = {1'b0, n};
  assign bx = {1'b0, reg_b};

  always_comb begin
    wide       = '0;
    res        = acc;
    cy         = carry_flag;
    load_acc   = 1'b1;
    load_flags = 1'b1;
    case (op)
      OP_ADD:  begin wide = nx + bx;       {cy, res} = wide; end
      OP_ADDP: begin wide = nx + bx + ONE; {cy, res} = wide; end
      OP_INC:  begin wide = nx + ONE;      {cy, res} = wide; end
      OP_SUB:  begin wide = nx - bx;       {cy, res} = wide; end
      OP_SUBM: begin wide = nx - bx - ONE; {cy, res} = wide; end
      OP_DEC:  begin wide = nx - ONE;      {cy, res} = wide; end
      OP_CMP:  begin wide = nx - bx;       {cy, res} = wide; load_acc = 1'b0; end
      OP_AND:  begin res = n & reg_b; cy = 1'b0; end
      OP_OR:   begin res = n | reg_b; cy = 1'b0; end
      OP_XOR:  begin res = n ^ reg_b; cy = 1'b0; end
      OP_NOT:  begin res = ~n;        cy = 1'b0; end
      OP_SHL:  begin res = {n[W-2:0], 1'b0}; cy = n[W-1]; end
      OP_SHR:  begin res = {1'b0, n[W-1:1]}; cy = n[0]; end
      OP_ROL:  res = {n[W-2:0], n[W-1]};
      OP_ROR:  res = {n[0], n[W-1:1]};
      default: begin load_acc = 1'b0; load_flags = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      zero_flag  <= 1'b0;
      carry_flag <= 1'b0;
      cmp_eq     <= 1'b0;
      cmp_lt     <= 1'b0;
      cmp_gt     <= 1'b0;
    end else if (strobe) begin
      if (load_acc)   acc <= res;
      if (load_flags) begin
        zero_flag  <= (res == '0);
        carry_flag <= cy;
      end
      if (op == OP_CMP) begin
        cmp_eq <= (n == reg_b);
        cmp_lt <= (n < reg_b);
        cmp_gt <= (n > reg_b);
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (acc == '0 && !zero_flag && !carry_flag && !cmp_eq && !cmp_lt && !cmp_gt));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(acc) && $stable(zero_flag) && $stable(carry_flag) &&
                 $stable({cmp_eq, cmp_lt, cmp_gt})));

  a_r8_rotate_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && (op == OP_ROL || op == OP_ROR) |=>
      ($stable(carry_flag) && $countones(acc) == $countones($past(n))));

  a_r9_zero_tracks_acc: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && op < OP_CMP |=> (zero_flag == (acc == '0)));

  a_r10_cmp_holds_acc: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && op == OP_CMP |=> ($stable(acc) && $countones({cmp_eq, cmp_lt, cmp_gt}) == 1));

  a_r10_verdict_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmp_eq, cmp_lt, cmp_gt}));

  a_r11_spare_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && op == 4'd15 |=> ($stable(acc) && $stable(zero_flag) && $stable(carry_flag)));

endmodule

// File: tb/tb_alu_acc8.sv
module tb_alu_acc8;

  typedef struct {
    logic [7:0] acc;
    logic z, c, eq, lt, gt;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strobe = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] sel = '0;
  logic [7:0] reg_a = '0, reg_b = '0, reg_c = '0, reg_d = '0;
  logic [7:0] acc;
  logic       zero_flag, carry_flag, cmp_eq, cmp_lt, cmp_gt;

  int tests = 0, fails = 0;
  exp_t q[$];
  exp_t m;

  always #4 clk = ~clk;

  alu_acc8 dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op), .sel(sel),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
    .acc(acc), .zero_flag(zero_flag), .carry_flag(carry_flag),
    .cmp_eq(cmp_eq), .cmp_lt(cmp_lt), .cmp_gt(cmp_gt)
  );

  function automatic void compare(exp_t e);
    tests++;
    if (acc !== e.acc || zero_flag !== e.z || carry_flag !== e.c ||
        cmp_eq !== e.eq || cmp_lt !== e.lt || cmp_gt !== e.gt) begin
      fails++;
      $display("FAIL %s: got acc=%h z=%b c=%b eq/lt/gt=%b%b%b, expected acc=%h z=%b c=%b eq/lt/gt=%b%b%b",
               e.tag, acc, zero_flag, carry_flag, cmp_eq, cmp_lt, cmp_gt,
               e.acc, e.z, e.c, e.eq, e.lt, e.gt);
    end
  endfunction

  always @(negedge clk)
    if (q.size() > 0) compare(q.pop_front());

  function automatic string tag_of(logic [3:0] o);
    case (o)
      0, 1, 8:  return "R4 add";
      2, 3, 9:  return "R5 sub";
      4, 5, 6, 7: return "R6 logic";
      10, 11:   return "R7 shift";
      12, 13:   return "R8 rotate";
      14:       return "R10 compare";
      default:  return "R11 spare code";
    endcase
  endfunction

  task automatic run(input logic s, input logic [3:0] o, input logic [1:0] sl,
                     input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] c, input logic [7:0] d, input string t);
    int nv, bv, r;
    logic [7:0] n8;
    @(negedge clk);
    strobe = s; op = o; sel = sl; reg_a = a; reg_b = b; reg_c = c; reg_d = d;
    n8 = (sl == 2'd1) ? c : (sl == 2'd2) ? d : a;
    nv = n8; bv = b;
    if (s && o != 4'd15) begin
      r = 0;
      case (o)
        0:  begin r = nv + bv;     m.c = (r > 255); end
        1:  begin r = nv + bv + 1; m.c = (r > 255); end
        8:  begin r = nv + 1;      m.c = (r > 255); end
        2, 14: begin r = nv - bv;  m.c = (r < 0); end
        3:  begin r = nv - bv - 1; m.c = (r < 0); end
        9:  begin r = nv - 1;      m.c = (r < 0); end
        4:  begin r = nv & bv; m.c = 0; end
        5:  begin r = nv | bv; m.c = 0; end
        6:  begin r = nv ^ bv; m.c = 0; end
        7:  begin r = 255 - nv; m.c = 0; end
        10: begin r = (nv * 2) % 256; m.c = (nv >= 128); end
        11: begin r = nv / 2; m.c = nv % 2; end
        12: r = (nv * 2) % 256 + nv / 128;
        13: r = nv / 2 + (nv % 2) * 128;
        default: r = 0;
      endcase
      r = r & 255;
      m.z = (r == 0);
      if (o == 4'd14) begin
        m.eq = (nv == bv); m.lt = (nv < bv); m.gt = (nv > bv);
      end else m.acc = r[7:0];
    end
    m.tag = (t != "") ? t : (s ? tag_of(o) : "R2 strobe low");
    @(posedge clk);
    #1;
    q.push_back(m);
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m = '{acc: 8'h00, z: 0, c: 0, eq: 0, lt: 0, gt: 0, tag: ""};
    repeat (3) @(posedge clk);
    @(negedge clk);
    m.tag = "R1 reset";
    compare(m);
    rst_n = 1'b1;

    run(1, 0, 0, 8'h80, 8'h80, 8'h11, 8'h22, "R4 R9 add wraps to zero");
    run(1, 1, 1, 8'h00, 8'h00, 8'hFF, 8'h22, "R3 R4 add-plus-one from C");
    run(1, 8, 2, 8'h00, 8'h00, 8'h00, 8'hFF, "R3 R4 inc from D");
    run(1, 2, 0, 8'h05, 8'h07, 8'h00, 8'h00, "R5 sub borrow");
    run(1, 3, 1, 8'h00, 8'hFF, 8'h00, 8'h00, "R3 R5 sub-minus-one from C");
    run(1, 9, 3, 8'h00, 8'h00, 8'h99, 8'h99, "R3 R5 dec sel3 takes A");
    run(1, 3, 0, 8'h09, 8'h08, 8'h00, 8'h00, "R5 R9 sub-minus-one to zero");
    run(1, 4, 0, 8'hF0, 8'h3C, 0, 0, "");
    run(1, 5, 2, 8'h00, 8'h0F, 0, 8'hA0, "");
    run(1, 6, 1, 8'h00, 8'hFF, 8'hFF, 0, "R6 R9 xor to zero");
    run(1, 7, 0, 8'h5A, 8'h00, 0, 0, "");
    run(1, 10, 0, 8'h81, 8'h00, 0, 0, "R7 shl carry out");
    run(1, 12, 0, 8'h01, 8'h00, 0, 0, "R8 rotate keeps set carry");
    run(1, 11, 0, 8'h02, 8'h00, 0, 0, "R7 shr carry clear");
    run(1, 13, 0, 8'h01, 8'h00, 0, 0, "R8 ror wraps bit");
    run(1, 0, 0, 8'h12, 8'h34, 0, 0, "");
    run(1, 14, 0, 8'h40, 8'h40, 0, 0, "R10 compare equal, acc held");
    run(1, 14, 1, 8'h00, 8'h40, 8'h10, 0, "R10 compare less");
    run(1, 14, 2, 8'h00, 8'h40, 0, 8'h90, "R10 compare greater");
    run(1, 0, 0, 8'h01, 8'h01, 0, 0, "R10 verdict held after add");
    run(0, 0, 0, 8'hFF, 8'hFF, 0, 0, "R2 strobe low add");
    run(0, 14, 0, 8'h00, 8'h01, 0, 0, "R2 strobe low compare");
    run(1, 15, 0, 8'hFF, 8'hFF, 0, 0, "R11 spare code");

    for (int i = 0; i < 400; i++)
      run(($urandom % 5) != 0, 4'($urandom), 2'($urandom), 8'($urandom),
          8'($urandom), 8'($urandom), 8'($urandom), "");

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule